// File: doc/BRIEF.md
# Multiplexed LCD Waveform Generator

This block produces the backplane and segment pin drive for a passive liquid crystal panel. It needs no analog level generator. Each backplane pin is either driven to 0, driven to supply, or released to high impedance. Outside the block, a pair of equal resistors on each backplane pin pulls a released pin to mid-supply. Segment pins are always driven, and only to 0 or supply. One block serves three panel organisations: a single backplane (static), two backplanes (duplex) and four backplanes (quadruplex). In quadruplex, S segments need only S/4 + 4 pins.

A frame is split into equal slots. In each slot one backplane is active and is driven high or low. Every other backplane in use is released to mid-supply. A segment pin is driven to the opposite level of the active backplane when its segment is to be dark, and to the same level when it is to be clear. Each backplane is driven high in the first half of the frame and low in the second half, and the segment polarity follows it. The net DC across every segment is therefore zero. The integrator sets the frame rate (30 Hz to 200 Hz) through the rate of the slot-advance strobe `tick`. For example, a quadruplex frame is eight ticks long.

Segment data enters as one on/off bit per segment pin per backplane. The block copies it into a shadow register only at a frame boundary, so no frame mixes old and new data.

Top module: `lcd_mux_drive`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become `com_out` = 0, `com_oe` = all ones and `seg_out` = 0. The slot counter and the shadow register become zero.
- R2: While `enable` is low, all backplane and segment pins are driven to 0 (`com_oe` all ones, `com_out` = 0, `seg_out` = 0), `tick` is ignored and the slot counter is held at 0. The first output after `enable` rises shows slot 0.
- R3: `mode` encoding: 2'b00 static (2 slots per frame), 2'b01 duplex (4 slots), 2'b10 quadruplex (8 slots), 2'b11 behaves as quadruplex. Each `tick` while enabled advances one slot, and the last slot wraps to slot 0.
- R4: With K backplanes in use (1, 2 or 4), backplane n is driven high in slot n and driven low in slot n+K.
- R5: A backplane in use that is not active in the current slot has `com_oe` = 0. Backplanes beyond the mode's count are driven low (`com_oe` = 1, `com_out` = 0).
- R6: Segment data bit `seg_bits[c*N_SEGPIN + p]` belongs to segment pin p on backplane c. In each slot, `seg_out[p]` is the inverse of the active backplane level when that bit is 1, and equal to that level when it is 0. Segment pins have no output enable.
- R7: For every segment pin, the level in slot n+K is the complement of the level in slot n, so each segment sees zero net DC over a frame.
- R8: `seg_bits` is copied into the shadow only on the tick that wraps the last slot to slot 0, and continuously while `enable` is low. A change in mid-frame does not appear until the next frame.
- R9: Outputs are registered. A tick sampled at clock edge E shows on the pins after edge E+1. Between ticks, with `enable` and `mode` steady, the pins hold.
- R10: In quadruplex mode exactly one backplane has its output enable set in every slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the display; low forces all pins to 0 |
| tick | input | 1 | One-cycle strobe that advances one slot |
| mode | input | 2 | Backplane count select (see R3) |
| seg_bits | input | 4*N_SEGPIN | Segment on/off bits, backplane-major |
| com_out | output | 4 | Backplane drive levels |
| com_oe | output | 4 | Backplane output enables (0 = released to mid-supply) |
| seg_out | output | N_SEGPIN | Segment pin levels |

## Verification
The assertions assume that `mode` changes only while `enable` is low. They also assume that `tick` is a single-cycle strobe. The polarity and single-backplane properties are qualified by the mode sampled one cycle earlier. The hold property requires `mode` to be equal over two consecutive cycles. The bench changes `mode` and reloads data only while `enable` is low, and pulses `tick` for one cycle with idle cycles after it. The one exception is the mid-frame data change, which exercises the shadow register.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

  localparam int MAX_COM = 4;
  localparam int SLOT_W  = 3;
  localparam int ACT_W   = $clog2(MAX_COM);

  typedef enum logic [1:0] {
    MODE_STATIC   = 2'b00,
    MODE_DUPLEX   = 2'b01,
    MODE_QUAD     = 2'b10,
    MODE_QUAD_ALT = 2'b11
  } drive_mode_e;

  // number of backplanes in use for a mode
  function automatic logic [SLOT_W-1:0] com_count(input logic [1:0] m);
    case (drive_mode_e'(m))
      MODE_STATIC: com_count = SLOT_W'(1);
      MODE_DUPLEX: com_count = SLOT_W'(2);
      default:     com_count = SLOT_W'(4);
    endcase
  endfunction

  // index of the final slot of a frame
  function automatic logic [SLOT_W-1:0] last_slot(input logic [1:0] m);
    case (drive_mode_e'(m))
      MODE_STATIC: last_slot = SLOT_W'(1);
      MODE_DUPLEX: last_slot = SLOT_W'(3);
      default:     last_slot = SLOT_W'(7);
    endcase
  endfunction

endpackage

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq
  import lcd_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              tick,
  input  logic [1:0]        mode,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_wrap
);

  logic [SLOT_W-1:0] last;
  logic              at_end;

  assign last       = last_slot(mode);
  assign at_end     = (slot >= last);
  assign frame_wrap = enable && tick && at_end;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      slot <= '0;
    end else if (tick) begin
      slot <= at_end ? '0 : slot + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/lcd_seg_shadow.sv
module lcd_seg_shadow #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcd_mux_pkg::*;
#(
  parameter int N_SEGPIN = 8,
  localparam int DATA_W  = MAX_COM * N_SEGPIN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [1:0]          mode,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [DATA_W-1:0]   shadow,
  output logic [MAX_COM-1:0]  com_out,
  output logic [MAX_COM-1:0]  com_oe,
  output logic [N_SEGPIN-1:0] seg_out
);

  logic [SLOT_W-1:0]   ncom;
  logic                level;
  logic [ACT_W-1:0]    act;
  logic [N_SEGPIN-1:0] row;
  logic [MAX_COM-1:0]  nxt_com;
  logic [MAX_COM-1:0]  nxt_oe;
  logic [N_SEGPIN-1:0] nxt_seg;

  assign ncom  = com_count(mode);
  assign level = (slot < ncom);

  always_comb begin
    case (drive_mode_e'(mode))
      MODE_STATIC: act = '0;
      MODE_DUPLEX: act = ACT_W'(slot[0]);
      default:     act = slot[ACT_W-1:0];
    endcase
  end

  for (genvar c = 0; c < MAX_COM; c++) begin : g_com
    always_comb begin
      if (ncom <= SLOT_W'(c)) begin
        nxt_oe[c]  = 1'b1;
        nxt_com[c] = 1'b0;
      end else if (act == ACT_W'(c)) begin
        nxt_oe[c]  = 1'b1;
        nxt_com[c] = level;
      end else begin
        nxt_oe[c]  = 1'b0;
        nxt_com[c] = 1'b0;
      end
    end
  end

  assign row     = shadow[act*N_SEGPIN +: N_SEGPIN];
  assign nxt_seg = row ^ {N_SEGPIN{level}};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      com_out <= '0;
      com_oe  <= '1;
      seg_out <= '0;
    end else begin
      com_out <= nxt_com;
      com_oe  <= nxt_oe;
      seg_out <= nxt_seg;
    end
  end

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
  import lcd_mux_pkg::*;
#(
  parameter int N_SEGPIN = 8,
  localparam int DATA_W  = MAX_COM * N_SEGPIN
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                tick,
  input  logic [1:0]          mode,
  input  logic [DATA_W-1:0]   seg_bits,
  output logic [MAX_COM-1:0]  com_out,
  output logic [MAX_COM-1:0]  com_oe,
  output logic [N_SEGPIN-1:0] seg_out
);

  logic [SLOT_W-1:0] slot;
  logic              frame_wrap;
  logic [DATA_W-1:0] shadow_q;

  lcd_slot_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .tick       (tick),
    .mode       (mode),
    .slot       (slot),
    .frame_wrap (frame_wrap)
  );

  lcd_seg_shadow #(.WIDTH(DATA_W)) u_shadow (
    .clk  (clk),
    .rst  (rst),
    .load (frame_wrap || !enable),
    .d    (seg_bits),
    .q    (shadow_q)
  );

  lcd_wave_gen #(.N_SEGPIN(N_SEGPIN)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .mode    (mode),
    .slot    (slot),
    .shadow  (shadow_q),
    .com_out (com_out),
    .com_oe  (com_oe),
    .seg_out (seg_out)
  );

endmodule

// File: rtl/lcd_mux_drive_chk.sv
module lcd_mux_drive_chk
  import lcd_mux_pkg::*;
#(
  parameter int N_SEGPIN = 8,
  localparam int DATA_W  = MAX_COM * N_SEGPIN
) (
  input logic                clk,
  input logic                rst,
  input logic                enable,
  input logic                tick,
  input logic [1:0]          mode,
  input logic [MAX_COM-1:0]  com_out,
  input logic [MAX_COM-1:0]  com_oe,
  input logic [N_SEGPIN-1:0] seg_out,
  input logic [DATA_W-1:0]   shadow
);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) || $past(rst)) |->
      (com_out == '0 && seg_out == '0 && com_oe == '1)); // R2

  AST_QUAD_ONE_COM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable) && $past(mode[1])) |->
      ($countones(com_oe) == 1)); // R10

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(enable, 1) && $past(enable, 2) &&
     !$past(tick, 2) && ($past(mode, 1) == $past(mode, 2))) |->
      ($stable(seg_out) && $stable(com_out) && $stable(com_oe))); // R9

  for (genvar c = 0; c < MAX_COM; c++) begin : g_pol
    AST_SEG_POLARITY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(enable) && $past(mode[1]) && com_oe[c]) |->
        (seg_out == ($past(shadow[c*N_SEGPIN +: N_SEGPIN]) ^ {N_SEGPIN{com_out[c]}}))); // R6
  end

endmodule

bind lcd_mux_drive lcd_mux_drive_chk #(.N_SEGPIN(N_SEGPIN)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .enable  (enable),
  .tick    (tick),
  .mode    (mode),
  .com_out (com_out),
  .com_oe  (com_oe),
  .seg_out (seg_out),
  .shadow  (shadow_q)
);

// File: tb/lcd_mux_drive_bench.sv
module lcd_mux_drive_bench;

  localparam int NP = 4;
  localparam int DW = 4 * NP;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic          tick = 1'b0;
  logic [1:0]    mode = 2'b10;
  logic [DW-1:0] seg_bits = '0;
  logic [3:0]    com_out;
  logic [3:0]    com_oe;
  logic [NP-1:0] seg_out;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  lcd_mux_drive #(.N_SEGPIN(NP)) u_lcd_mux_drive (
    .clk(clk), .rst(rst), .enable(enable), .tick(tick), .mode(mode),
    .seg_bits(seg_bits), .com_out(com_out), .com_oe(com_oe), .seg_out(seg_out)
  );

  // {mode, data, ticks, exp_oe, exp_com, exp_seg}; data bit c*4+p
  localparam int NV = 15;
  localparam logic [33:0] VEC [0:NV-1] = '{
    {2'd2, 16'h1234, 4'd0, 4'b0001, 4'b0001, 4'hB},
    {2'd2, 16'h1234, 4'd1, 4'b0010, 4'b0010, 4'hC},
    {2'd2, 16'h1234, 4'd3, 4'b1000, 4'b1000, 4'hE},
    {2'd2, 16'h1234, 4'd4, 4'b0001, 4'b0000, 4'h4},
    {2'd2, 16'h1234, 4'd6, 4'b0100, 4'b0000, 4'h2},
    {2'd2, 16'h1234, 4'd7, 4'b1000, 4'b0000, 4'h1},
    {2'd2, 16'h1234, 4'd8, 4'b0001, 4'b0001, 4'hB},
    {2'd1, 16'h00A6, 4'd0, 4'b1101, 4'b0001, 4'h9},
    {2'd1, 16'h00A6, 4'd1, 4'b1110, 4'b0010, 4'h5},
    {2'd1, 16'h00A6, 4'd2, 4'b1101, 4'b0000, 4'h6},
    {2'd1, 16'h00A6, 4'd3, 4'b1110, 4'b0000, 4'hA},
    {2'd1, 16'h00A6, 4'd4, 4'b1101, 4'b0001, 4'h9},
    {2'd0, 16'hFFF5, 4'd0, 4'b1111, 4'b0001, 4'hA},
    {2'd0, 16'hFFF5, 4'd1, 4'b1111, 4'b0000, 4'h5},
    {2'd0, 16'hFFF5, 4'd2, 4'b1111, 4'b0001, 4'hA}
  };

  task automatic check(input string req, input logic [3:0] eoe,
                       input logic [3:0] ecom, input logic [NP-1:0] eseg);
    tests++;
    if (com_oe !== eoe || com_out !== ecom || seg_out !== eseg) begin
      fails++;
      $display("FAIL %s: oe=%b com=%b seg=%h expected oe=%b com=%b seg=%h",
               req, com_oe, com_out, seg_out, eoe, ecom, eseg);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] m, input logic [DW-1:0] d);
    @(negedge clk);
    enable = 1'b0; mode = m; seg_bits = d;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NP-1:0] cap [0:7];
    repeat (3) @(negedge clk);
    check("R1 reset", 4'b1111, 4'b0000, '0);
    rst = 1'b0;

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      start(VEC[i][33:32], VEC[i][31:16]);
      for (int t = 0; t < int'(VEC[i][15:12]); t++) pulse_tick();
      settle();
      check("R3 R4 R5 R6 vector", VEC[i][11:8], VEC[i][7:4], VEC[i][3:0]);
    end

    // R2: disabled, ticks ignored, all low
    @(negedge clk) enable = 1'b0; mode = 2'b10; seg_bits = 16'hFFFF;
    repeat (3) pulse_tick();
    settle();
    check("R2 disabled", 4'b1111, 4'b0000, '0);
    @(negedge clk) enable = 1'b1;
    settle();
    check("R2 first slot after enable", 4'b0001, 4'b0001, 4'h0);

    // R9: one cycle after a tick's edge the pins still show the old slot
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R9 latency hold", 4'b0001, 4'b0001, 4'h0);
    @(negedge clk);
    check("R9 latency update", 4'b0010, 4'b0010, 4'h0);

    // R8: mid-frame data change waits for the frame boundary
    start(2'b10, 16'h1234);
    repeat (2) pulse_tick();
    @(negedge clk) seg_bits = 16'h8765;
    pulse_tick();
    settle();
    check("R8 old frame kept", 4'b1000, 4'b1000, 4'hE);
    repeat (5) pulse_tick();
    settle();
    check("R8 new frame", 4'b0001, 4'b0001, 4'hA);

    // R3: mode 2'b11 behaves as quadruplex
    start(2'b11, 16'h1234);
    pulse_tick();
    settle();
    check("R3 mode3 as quad", 4'b0010, 4'b0010, 4'hC);

    // R7: second-half levels complement first-half levels
    start(2'b10, 16'h5A3C);
    for (int s = 0; s < 8; s++) begin
      cap[s] = seg_out;
      pulse_tick();
      settle();
    end
    for (int n = 0; n < 4; n++) begin
      tests++;
      if ((cap[n] ^ cap[n+4]) !== 4'hF) begin
        fails++;
        $display("FAIL R7 slot %0d: xor=%h expected=%h", n, cap[n] ^ cap[n+4], 4'hF);
      end
    end

    // R1: reset while running
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    check("R1 reset while running", 4'b1111, 4'b0000, '0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule